// File: doc/BRIEF.md
# Interrupt Request Pacing Controller

This block combines a group of interrupt sources, each with its own enable, into one request line to a host processor. It limits how often the host is interrupted. Each time the request line goes low, the block can hold the line low for a quiet period of programmable length before it may rise again. The power-management interrupt input ignores the quiet period. The master interrupt state can always be read, whatever the quiet period and the output enable are doing.

A single 32-bit configuration word is written and read through a plain register port. The word holds five fields:
- an 8-bit interval, in units of a 10 µs tick;
- a self-clearing restart command;
- a quiet-period status bit;
- the read-only master interrupt bit;
- the output enable.

A prescaler divides the clock down to the 10 µs tick. It is sized from the clock-frequency parameter and restarts whenever a quiet period starts, so a period lasts exactly interval × (CLK_HZ / 100000) clock cycles.

Top module: `irq_pacer`

## Requirements
- R1: While reset is held and directly after it, `irq_out` is 0 and `rd_data` bits 31:24, 13 and 8 read 0 (interval zero, no quiet period, output disabled).
- R2: `rd_data` bit 12 reads 1 exactly when some source has both `src_req` and `src_en` set, or when `pm_req` is set. This holds whatever the output enable and the quiet period are.
- R3: `irq_out` is 1 only when the output enable (bit 8) is 1 and the master bit is 1, and in addition either no quiet period is active or `pm_req` is 1. `irq_out` follows its inputs in the same cycle.
- R4: A quiet period starts at the clock edge that ends the first cycle in which `irq_out` is low after being high, provided the interval is non-zero. From the next cycle, bit 13 reads 1.
- R5: A quiet period stays active for exactly interval × (CLK_HZ/100000) clock cycles, and during it `irq_out` stays 0 unless `pm_req` is set. When it ends, a pending interrupt drives `irq_out` again.
- R6: A write with interval 0 in bits 31:24 ends any quiet period at that edge and resets the counter. An interrupt that was being held back appears on `irq_out` in the next cycle.
- R7: A non-zero interval written while a quiet period is running does not change that period's length. The next quiet period uses the new value.
- R8: A write with bit 14 set and a non-zero interval starts a fresh quiet period of the written length, whether or not a quiet period is already running. If this write falls on the same edge at which a running period would expire, the restart wins. Bit 14 always reads 0.
- R9: `pm_req` drives `irq_out` high during a quiet period whenever the output enable is set.
- R10: `rd_data` bits 23:14, 11:9 and 7:0 always read 0.
- R11: A write changes the register only at the next rising clock edge. Before that edge, `rd_data` shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | N_SRC | Interrupt request of each source |
| src_en | input | N_SRC | Enable of each source |
| pm_req | input | 1 | Power-management interrupt; bypasses the quiet period |
| wr_en | input | 1 | Writes `wr_data` into the configuration word |
| wr_data | input | 32 | Write data: interval 31:24, restart 14, output enable 8 |
| rd_data | output | 32 | Read data: interval 31:24, quiet status 13, master 12, output enable 8 |
| irq_out | output | 1 | Interrupt request line to the host |

## Verification
A restart write and the natural expiry of a running quiet period can fall on the same clock edge. The bench provokes this by issuing the restart write exactly interval × tick cycles after an earlier restart. It then requires bit 13 to stay 1 across that edge and to remain 1 for a full fresh period. A second overlap, the disable write against a held-back interrupt, is judged by requiring `irq_out` to rise in the cycle right after the write edge.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;
   localparam int WORD_W   = 32;
   localparam int INTV_W   = 8;
   localparam int INTV_LSB = 24;
   localparam int CLR_BIT  = 14;
   localparam int STS_BIT  = 13;
   localparam int MST_BIT  = 12;
   localparam int OE_BIT   = 8;
   localparam int TICK_HZ  = 100_000;

   function automatic logic [WORD_W-1:0] pack_word(
      input logic [INTV_W-1:0] intv,
      input logic              sts,
      input logic              mst,
      input logic              oe);
      logic [WORD_W-1:0] w;
      w = '0;
      w[INTV_LSB +: INTV_W] = intv;
      w[STS_BIT] = sts;
      w[MST_BIT] = mst;
      w[OE_BIT]  = oe;
      return w;
   endfunction
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("irq_tick_gen: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         logic unused_ports;
         assign unused_ports = ^{clk, rst_n, restart};
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             pcnt <= '0;
            else if (restart)       pcnt <= '0;
            else if (pcnt == LAST)  pcnt <= '0;
            else                    pcnt <= pcnt + 1'b1;
         end
         assign tick = (pcnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
   parameter int N_SRC = 8
) (
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_SRC-1:0] src_en,
   input  logic             pm_req,
   output logic             master
);
   generate
      if (N_SRC < 1) begin : g_bad_n
         $error("irq_src_merge: N_SRC must be at least 1");
      end
   endgenerate
   logic [N_SRC-1:0] live;
   assign live   = src_req & src_en;
   assign master = (|live) | pm_req;
endmodule

// File: rtl/irq_quiet_timer.sv
module irq_quiet_timer #(
   parameter int IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          kill,
   input  logic          start,
   input  logic [IW-1:0] start_len,
   output logic          quiet
);
   logic [IW-1:0] limit;
   logic [IW-1:0] cnt;
   logic          last_tick;

   assign last_tick = (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet <= 1'b0;
         cnt   <= '0;
         limit <= '0;
      end else if (kill) begin
         quiet <= 1'b0;
         cnt   <= '0;
      end else if (start) begin
         quiet <= 1'b1;
         cnt   <= '0;
         limit <= start_len;
      end else if (quiet && tick) begin
         if (last_tick) begin
            quiet <= 1'b0;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_pacer.sv
module irq_pacer
   import irq_pacer_pkg::*;
#(
   parameter int N_SRC  = 8,
   parameter int CLK_HZ = 100_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req,
   input  logic [N_SRC-1:0]  src_en,
   input  logic              pm_req,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              irq_out
);
   localparam int TICK_DIV = CLK_HZ / TICK_HZ;

   generate
      if (CLK_HZ < TICK_HZ) begin : g_bad_clk
         $error("irq_pacer: CLK_HZ must be at least 100 kHz");
      end
      if (CLK_HZ % TICK_HZ != 0) begin : g_inexact_clk
         $warning("irq_pacer: CLK_HZ is not a multiple of 100 kHz, tick rounds down");
      end
   endgenerate

   logic [INTV_W-1:0] intv_q;
   logic              oe_q;
   logic              pin_q;
   logic              master;
   logic              quiet;
   logic              tick;

   logic [INTV_W-1:0] wr_intv;
   logic [INTV_W-1:0] eff_intv;
   logic              zero_wr;
   logic              clr_wr;
   logic              fall;
   logic              start;

   irq_src_merge #(.N_SRC(N_SRC)) u_merge (
      .src_req (src_req),
      .src_en  (src_en),
      .pm_req  (pm_req),
      .master  (master)
   );

   assign wr_intv  = wr_data[INTV_LSB +: INTV_W];
   assign eff_intv = wr_en ? wr_intv : intv_q;
   assign zero_wr  = wr_en && (wr_intv == '0);
   assign clr_wr   = wr_en && wr_data[CLR_BIT] && (wr_intv != '0);
   assign fall     = pin_q && !irq_out;
   assign start    = clr_wr || (fall && (eff_intv != '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intv_q <= '0;
         oe_q   <= 1'b0;
      end else if (wr_en) begin
         intv_q <= wr_intv;
         oe_q   <= wr_data[OE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= irq_out;
   end

   irq_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .tick    (tick)
   );

   irq_quiet_timer #(.IW(INTV_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .kill      (zero_wr),
      .start     (start),
      .start_len (eff_intv),
      .quiet     (quiet)
   );

   assign irq_out = oe_q && master && (!quiet || pm_req);
   assign rd_data = pack_word(intv_q, quiet, master, oe_q);

   logic unused_wr;
   assign unused_wr = ^{wr_data[23:15], wr_data[13:9], wr_data[7:0]};
endmodule

// File: rtl/irq_pacer_chk.sv
module irq_pacer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pm_req,
   input logic        wr_en,
   input logic [31:0] wr_data,
   input logic        irq_out,
   input logic        master,
   input logic        oe_q,
   input logic        quiet,
   input logic [7:0]  intv_q
);
   AST_PIN_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (oe_q && master)); // R3

   AST_QUIET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && !pm_req) |-> !irq_out); // R5

   AST_FALL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_out) && !wr_en && (intv_q != 8'd0)) |=> quiet); // R4

   AST_ZERO_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_data[31:24] == 8'd0)) |=> !quiet); // R6

   AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[14] && (wr_data[31:24] != 8'd0)) |=> quiet); // R8

   AST_PM_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_req && oe_q) |-> irq_out); // R9
endmodule

bind irq_pacer irq_pacer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pm_req  (pm_req),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .irq_out (irq_out),
   .master  (master),
   .oe_q    (oe_q),
   .quiet   (quiet),
   .intv_q  (intv_q)
);

// File: tb/irq_pacer_test.sv
module irq_pacer_test;
   localparam int NS = 4;
   localparam int HZ = 1_000_000;
   localparam int DIV = HZ / 100_000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic [NS-1:0] src_en = '0;
   logic          pm_req = 1'b0;
   logic          wr_en = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic          irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_pacer #(.N_SRC(NS), .CLK_HZ(HZ)) uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
      .pm_req(pm_req), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq_out(irq_out)
   );

   function automatic logic [31:0] cfg(input logic [7:0] iv, input logic oe, input logic clr);
      logic [31:0] w;
      w = '0;
      w[31:24] = iv;
      w[14] = clr;
      w[8] = oe;
      return w;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [31:0] w);
      wr_en = 1'b1;
      wr_data = w;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
      #1;
   endtask

   // Raise source 0 with the pin free, then drop it: quiet starts at the next edge, returns at s0.
   task automatic fire_and_drop();
      src_en[0] = 1'b1;
      src_req[0] = 1'b1;
      step(1);
      src_req[0] = 1'b0;
      step(1);
   endtask

   task automatic t_reset();
      step(1);
      chk(irq_out == 1'b0, "R1 pin", {31'd0, irq_out}, 32'd0);
      chk(rd_data == 32'd0, "R1 word", rd_data, 32'd0);
   endtask

   task automatic t_master();
      src_en = 4'b0110;
      src_req = 4'b1001;
      #1;
      chk(rd_data[12] == 1'b0, "R2 unenabled", {31'd0, rd_data[12]}, 32'd0);
      src_req = 4'b0100;
      #1;
      chk(rd_data[12] == 1'b1, "R2 enabled src", {31'd0, rd_data[12]}, 32'd1);
      chk(irq_out == 1'b0, "R3 oe off", {31'd0, irq_out}, 32'd0);
      wr_en = 1'b1;
      wr_data = cfg(8'd0, 1'b1, 1'b0);
      #1;
      chk(rd_data[8] == 1'b0, "R11 before edge", {31'd0, rd_data[8]}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
      #1;
      chk(rd_data[8] == 1'b1, "R11 after edge", {31'd0, rd_data[8]}, 32'd1);
      chk(irq_out == 1'b1, "R3 pin on", {31'd0, irq_out}, 32'd1);
      src_req = '0;
      src_en = '0;
      pm_req = 1'b1;
      #1;
      chk(rd_data[12] == 1'b1, "R2 pm", {31'd0, rd_data[12]}, 32'd1);
      pm_req = 1'b0;
      step(2);
   endtask

   task automatic t_quiet();
      wr(cfg(8'd3, 1'b1, 1'b0));
      fire_and_drop();
      chk(rd_data[13] == 1'b1, "R4 status set", {31'd0, rd_data[13]}, 32'd1);
      src_req[0] = 1'b1;
      #1;
      chk(rd_data[12] == 1'b1 && irq_out == 1'b0, "R2 master in quiet", rd_data, 32'h0300_3100);
      step(29);
      chk(irq_out == 1'b0 && rd_data[13] == 1'b1, "R5 last quiet cycle", {30'd0, rd_data[13], irq_out}, 32'd2);
      step(1);
      chk(irq_out == 1'b1 && rd_data[13] == 1'b0, "R5 release", {30'd0, rd_data[13], irq_out}, 32'd1);
      src_req = '0;
      src_en = '0;
      step(1);
   endtask

   task automatic t_zero();
      wr(cfg(8'd5, 1'b1, 1'b0));
      fire_and_drop();
      src_req[0] = 1'b1;
      step(3);
      chk(irq_out == 1'b0, "R5 held back", {31'd0, irq_out}, 32'd0);
      wr(cfg(8'd0, 1'b1, 1'b0));
      chk(irq_out == 1'b1 && rd_data[13] == 1'b0, "R6 zero delivers", {30'd0, rd_data[13], irq_out}, 32'd1);
      src_req = '0;
      step(1);
      chk(rd_data[13] == 1'b0, "R6 no new period", {31'd0, rd_data[13]}, 32'd0);
      src_en = '0;
   endtask

   task automatic t_newval();
      wr(cfg(8'd2, 1'b1, 1'b0));
      fire_and_drop();
      wr(cfg(8'd4, 1'b1, 1'b0));
      step(18);
      chk(rd_data[13] == 1'b1, "R7 old length runs", {31'd0, rd_data[13]}, 32'd1);
      step(1);
      chk(rd_data[13] == 1'b0, "R7 old length ends", {31'd0, rd_data[13]}, 32'd0);
      fire_and_drop();
      step(39);
      chk(rd_data[13] == 1'b1, "R7 new length runs", {31'd0, rd_data[13]}, 32'd1);
      step(1);
      chk(rd_data[13] == 1'b0, "R7 new length ends", {31'd0, rd_data[13]}, 32'd0);
      src_en = '0;
   endtask

   task automatic t_clear();
      wr(cfg(8'd3, 1'b1, 1'b1));
      chk(rd_data[13] == 1'b1, "R8 clear starts", {31'd0, rd_data[13]}, 32'd1);
      chk(rd_data[14] == 1'b0, "R8 self clear", {31'd0, rd_data[14]}, 32'd0);
      step(29);
      chk(rd_data[13] == 1'b1, "R8 before collision", {31'd0, rd_data[13]}, 32'd1);
      wr(cfg(8'd3, 1'b1, 1'b1));
      chk(rd_data[13] == 1'b1, "R8 restart beats expiry", {31'd0, rd_data[13]}, 32'd1);
      step(29);
      chk(rd_data[13] == 1'b1, "R8 fresh period runs", {31'd0, rd_data[13]}, 32'd1);
      step(1);
      chk(rd_data[13] == 1'b0, "R8 fresh period ends", {31'd0, rd_data[13]}, 32'd0);
   endtask

   task automatic t_pm();
      wr(cfg(8'd3, 1'b1, 1'b0));
      fire_and_drop();
      src_req[0] = 1'b1;
      #1;
      chk(irq_out == 1'b0, "R5 blocked before pm", {31'd0, irq_out}, 32'd0);
      pm_req = 1'b1;
      #1;
      chk(irq_out == 1'b1, "R9 pm bypass", {31'd0, irq_out}, 32'd1);
      pm_req = 1'b0;
      src_req = '0;
      src_en = '0;
      step(40);
   endtask

   task automatic t_reserved();
      wr(32'hFFFF_FFFF);
      chk(rd_data == 32'hFF00_2100, "R10 reserved zero", rd_data, 32'hFF00_2100);
      wr(cfg(8'd0, 1'b0, 1'b0));
      chk(rd_data == 32'd0, "R10 cleared", rd_data, 32'd0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200_000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      #1;
      chk(irq_out == 1'b0, "R1 pin in reset", {31'd0, irq_out}, 32'd0);
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_master();
      t_quiet();
      t_zero();
      t_newval();
      t_clear();
      t_pm();
      t_reserved();
      done = 1;
      finish_run();
   end
endmodule